// File: doc/BRIEF.md
# Self-Clock Mode and Wake-up Controller

This controller decides whether the system runs from the crystal-derived clock or from an internal self-clock. It watches a clock-monitor failure pulse, handles entry into and exit from full stop, and drives the oscillator enable, the clock-monitor enable and the start of the clock quality check. The oscillator, the PLL and the quality-check counter are outside the block. They show up only as a failure pulse and a done/pass result.

Two software-visible control bits live inside the block. The self-clock enable bit picks the reaction to a crystal failure. When it is clear, the block asks for a monitor reset. When it is set, the block falls back to the self-clock and tries to recover. This bit can be written once in normal mode and freely in special mode, and it can never be cleared while the self-clock is in use. The fast-wake-up bit lets a wake from full stop resume at once on the self-clock, with the oscillator parked. Clearing that bit later brings the crystal back through a quality check. A sticky flag records each return to the crystal clock and each failure-driven switch to the self-clock. Software clears it with a write-one strobe.

Top module: `selfclk_wake_ctrl`

## Requirements
- R1: In normal mode (specialMode=0) only the first write of the self-clock enable bit takes effect, and later writes are ignored. In special mode (specialMode=1) every write takes effect.
- R2: A write of 0 to the self-clock enable bit while scMode=1 is ignored in either mode.
- R3: In crystal mode with the self-clock enable bit 0, a clkFail pulse gives a one-cycle monResetReq on the next cycle and the clock stays on the crystal. With the bit at 1, the next cycle shows scMode=1, selOsc=0, a one-cycle qcStart and scFlag=1.
- R4: When the self-clock enable bit is 0, the fast-wake-up bit has no effect, and a wake from stop takes the ordinary path of R11.
- R5: With both bits set, a wakeEvt in stop gives scMode=1, selOsc=0, oscEn=0 and monEn=0 on the next cycle, and scFlag is not set.
- R6: After a fast wake the block holds scMode=1 with oscEn=0 and monEn=0 while the fast-wake-up bit stays 1, and qcDone is ignored in that state.
- R7: The cycle after the fast-wake-up bit has been cleared, the block raises oscEn and monEn and pulses qcStart for one cycle while scMode stays 1.
- R8: When a quality check passes (qcDone=1, qcPass=1) in self-clock mode, the next cycle shows selOsc=1, scMode=0 and scFlag=1.
- R9: When a quality check fails (qcDone=1, qcPass=0) in self-clock mode with the oscillator running, scMode stays 1 and qcStart pulses again.
- R10: scFlag stays set until a flagClrStb cycle. If a set event and flagClrStb arrive in the same cycle, the set wins.
- R11: An ordinary wake from stop gives oscEn=1, selOsc=0, monEn=0 and a qcStart pulse. A failed check pulses qcStart again. A passed check selects the crystal (selOsc=1, oscEn=1, monEn=1) without setting scFlag.
- R12: During and just after reset the outputs are selOsc=1, oscEn=1, monEn=1, and qcStart, monResetReq, scMode and scFlag are 0. Both control bits are 0 and the write-once lock is open.
- R13: In crystal mode a stopReq gives oscEn=0 and monEn=0 with selOsc=1 on the next cycle. A clkFail in the same cycle takes priority over stopReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode, which lifts the write-once lock |
| scEnWrStb | input | 1 | Write strobe for the self-clock enable bit |
| scEnWrData | input | 1 | Value written to the self-clock enable bit |
| fastWkWrStb | input | 1 | Write strobe for the fast-wake-up bit |
| fastWkWrData | input | 1 | Value written to the fast-wake-up bit |
| flagClrStb | input | 1 | Write-one-to-clear strobe for scFlag |
| stopReq | input | 1 | Request to enter full stop |
| wakeEvt | input | 1 | Wake-up event while in full stop |
| clkFail | input | 1 | Crystal clock failure pulse from the clock monitor |
| qcDone | input | 1 | Quality check finished this cycle |
| qcPass | input | 1 | Quality check result, valid with qcDone |
| selOsc | output | 1 | 1 = system clock from the crystal path |
| oscEn | output | 1 | Oscillator enable |
| monEn | output | 1 | Clock-monitor enable |
| qcStart | output | 1 | One-cycle start pulse for the quality check |
| monResetReq | output | 1 | One-cycle clock-monitor reset request |
| scMode | output | 1 | 1 = running on the self-clock |
| scFlag | output | 1 | Sticky self-clock interrupt flag |

## Verification
The assertions assume that clkFail, qcDone and wakeEvt are single-cycle events. They also assume that qcDone arrives only after a qcStart, and that stopReq, clkFail and the register strobes are never X after reset. The stimulus drives every input as a pulse lasting one cycle and raises qcDone only in states where a check is running, except for one deliberate pulse in the fast-wake hold state. That pulse shows that the result is ignored there. Same-cycle collisions are produced on purpose only for the failure/stop and set/clear priority cases.

// File: rtl/selfclk_pkg.sv
package selfclk_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN     = 3'd0,  // crystal clock selected
    ST_STOP    = 3'd1,  // full stop, oscillator parked
    ST_WAKECHK = 3'd2,  // ordinary wake, quality check running
    ST_SCHOLD  = 3'd3,  // fast wake hold, oscillator parked
    ST_SCCHK   = 3'd4   // self-clock with recovery check running
  } clkState_e;

  // strobes from control to the register datapath
  typedef struct packed {
    logic setFlag;      // raise the sticky flag this cycle
    logic inSelfClock;  // self-clock currently in use
  } ctlStrobe_t;

endpackage

// File: rtl/selfclk_regs.sv
module selfclk_regs
  import selfclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       specialMode,
  input  logic       scEnWrStb,
  input  logic       scEnWrData,
  input  logic       fastWkWrStb,
  input  logic       fastWkWrData,
  input  logic       flagClrStb,
  input  ctlStrobe_t ctl,
  output logic       scEn,
  output logic       fastWk,
  output logic       scFlag
);

  logic lockQ;
  logic scEnQ;
  logic fastWkQ;
  logic flagQ;
  logic scEnAccept;

  // normal mode honours the lock; clearing is refused while on the self-clock
  always_comb begin
    scEnAccept = scEnWrStb && (specialMode || !lockQ);
    if (ctl.inSelfClock && !scEnWrData) scEnAccept = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      scEnQ   <= 1'b0;
      fastWkQ <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (scEnAccept) begin
        scEnQ <= scEnWrData;
        if (!specialMode) lockQ <= 1'b1;
      end
      if (fastWkWrStb) fastWkQ <= fastWkWrData;
      if (ctl.setFlag)      flagQ <= 1'b1;
      else if (flagClrStb)  flagQ <= 1'b0;
    end
  end

  assign scEn   = scEnQ;
  assign fastWk = fastWkQ;
  assign scFlag = flagQ;

endmodule

// File: rtl/selfclk_fsm.sv
module selfclk_fsm
  import selfclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scEn,
  input  logic       fastWk,
  input  logic       stopReq,
  input  logic       wakeEvt,
  input  logic       clkFail,
  input  logic       qcDone,
  input  logic       qcPass,
  output ctlStrobe_t ctl,
  output logic       selOsc,
  output logic       oscEn,
  output logic       monEn,
  output logic       qcStart,
  output logic       monResetReq,
  output logic       scMode
);

  clkState_e stateQ, stateD;
  logic qcStartQ, qcStartD;
  logic mrQ, mrD;
  logic setFlagD;

  always_comb begin
    stateD   = stateQ;
    qcStartD = 1'b0;
    mrD      = 1'b0;
    setFlagD = 1'b0;
    unique case (stateQ)
      ST_RUN: begin
        if (clkFail) begin
          if (scEn) begin
            stateD   = ST_SCCHK;
            qcStartD = 1'b1;
            setFlagD = 1'b1;
          end else begin
            mrD = 1'b1;
          end
        end else if (stopReq) begin
          stateD = ST_STOP;
        end
      end
      ST_STOP: begin
        if (wakeEvt) begin
          if (scEn && fastWk) begin
            stateD = ST_SCHOLD;
          end else begin
            stateD   = ST_WAKECHK;
            qcStartD = 1'b1;
          end
        end
      end
      ST_WAKECHK: begin
        if (qcDone) begin
          if (qcPass) stateD = ST_RUN;
          else        qcStartD = 1'b1;
        end
      end
      ST_SCHOLD: begin
        if (stopReq) begin
          stateD = ST_STOP;
        end else if (!fastWk) begin
          stateD   = ST_SCCHK;
          qcStartD = 1'b1;
        end
      end
      ST_SCCHK: begin
        if (stopReq) begin
          stateD = ST_STOP;
        end else if (qcDone) begin
          if (qcPass) begin
            stateD   = ST_RUN;
            setFlagD = 1'b1;
          end else begin
            qcStartD = 1'b1;
          end
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_RUN;
      qcStartQ <= 1'b0;
      mrQ      <= 1'b0;
    end else begin
      stateQ   <= stateD;
      qcStartQ <= qcStartD;
      mrQ      <= mrD;
    end
  end

  // Moore decode of the clock controls
  always_comb begin
    selOsc = 1'b0;
    oscEn  = 1'b0;
    monEn  = 1'b0;
    scMode = 1'b0;
    unique case (stateQ)
      ST_RUN:     begin selOsc = 1'b1; oscEn = 1'b1; monEn = 1'b1; end
      ST_STOP:    begin selOsc = 1'b1; end
      ST_WAKECHK: begin oscEn = 1'b1; end
      ST_SCHOLD:  begin scMode = 1'b1; end
      ST_SCCHK:   begin oscEn = 1'b1; monEn = 1'b1; scMode = 1'b1; end
      default:    begin selOsc = 1'b1; end
    endcase
  end

  assign qcStart         = qcStartQ;
  assign monResetReq     = mrQ;
  assign ctl.setFlag     = setFlagD;
  assign ctl.inSelfClock = scMode;

endmodule

// File: rtl/selfclk_wake_ctrl.sv
module selfclk_wake_ctrl
  import selfclk_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic specialMode,
  input  logic scEnWrStb,
  input  logic scEnWrData,
  input  logic fastWkWrStb,
  input  logic fastWkWrData,
  input  logic flagClrStb,
  input  logic stopReq,
  input  logic wakeEvt,
  input  logic clkFail,
  input  logic qcDone,
  input  logic qcPass,
  output logic selOsc,
  output logic oscEn,
  output logic monEn,
  output logic qcStart,
  output logic monResetReq,
  output logic scMode,
  output logic scFlag
);

  ctlStrobe_t ctl;
  logic scEn;
  logic fastWk;

  selfclk_regs u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .specialMode  (specialMode),
    .scEnWrStb    (scEnWrStb),
    .scEnWrData   (scEnWrData),
    .fastWkWrStb  (fastWkWrStb),
    .fastWkWrData (fastWkWrData),
    .flagClrStb   (flagClrStb),
    .ctl          (ctl),
    .scEn         (scEn),
    .fastWk       (fastWk),
    .scFlag       (scFlag)
  );

  selfclk_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .scEn        (scEn),
    .fastWk      (fastWk),
    .stopReq     (stopReq),
    .wakeEvt     (wakeEvt),
    .clkFail     (clkFail),
    .qcDone      (qcDone),
    .qcPass      (qcPass),
    .ctl         (ctl),
    .selOsc      (selOsc),
    .oscEn       (oscEn),
    .monEn       (monEn),
    .qcStart     (qcStart),
    .monResetReq (monResetReq),
    .scMode      (scMode)
  );

endmodule

// File: rtl/selfclk_chk.sv
module selfclk_chk (
  input logic clk,
  input logic rstN,
  input logic clkFail,
  input logic stopReq,
  input logic qcDone,
  input logic qcPass,
  input logic flagClrStb,
  input logic selOsc,
  input logic oscEn,
  input logic monEn,
  input logic qcStart,
  input logic monResetReq,
  input logic scMode,
  input logic scFlag,
  input logic scEn,
  input logic fastWk
);

  // self-clock in use implies the enable bit was set and cannot have been cleared
  assert_sc_keeps_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    scMode |-> scEn);

  assert_fail_gives_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkFail && selOsc && oscEn && !scMode && !scEn) |=> (monResetReq && selOsc));

  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({qcStart, monResetReq}));

  assert_fastwake_noflag_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(scMode) && !oscEn) |-> !$rose(scFlag));

  assert_hold_while_bit_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (scMode && !oscEn && fastWk && !stopReq) |=> (scMode && !oscEn && !monEn));

  assert_osc_start_checks_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> qcStart);

  assert_return_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(scMode) && selOsc && oscEn) |-> scFlag);

  assert_failed_check_retries_R9: assert property (@(posedge clk) disable iff (!rstN)
    (scMode && oscEn && qcDone && !qcPass && !stopReq) |=> (scMode && qcStart));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (scFlag && !flagClrStb) |=> scFlag);

  assert_stop_parks_osc_R13: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !clkFail && selOsc && oscEn && !scMode) |=> (!oscEn && !monEn && selOsc));

endmodule

bind selfclk_wake_ctrl selfclk_chk u_chk (.*);

// File: tb/sim_selfclk_wake_ctrl.sv
`timescale 1ns/1ps
module sim_selfclk_wake_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic specialMode, scEnWrStb, scEnWrData, fastWkWrStb, fastWkWrData;
  logic flagClrStb, stopReq, wakeEvt, clkFail, qcDone, qcPass;
  logic selOsc, oscEn, monEn, qcStart, monResetReq, scMode, scFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  selfclk_wake_ctrl u0 (.*);

  // input bits: sp seS seD fwS fwD clr stop wake fail qd qp
  // expected  : sel osc mon qs mr sc fl
  localparam int NV = 24;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {11'b00000000000, 7'b1110000},  // idle
    {11'b00000000100, 7'b1110100},  // R3 fail with enable 0
    {11'b01100000000, 7'b1110000},  // R1 first write 1
    {11'b01000000000, 7'b1110000},  // R1 second write 0 (locked)
    {11'b00000000100, 7'b0111011},  // R1 R3 fail with enable 1
    {11'b00000000010, 7'b0111011},  // R9 failed check
    {11'b00000100000, 7'b0110010},  // R10 clear
    {11'b00000000011, 7'b1110001},  // R8 pass
    {11'b00000100000, 7'b1110000},  // R10 clear
    {11'b00011000000, 7'b1110000},  // set fast wake
    {11'b00000010000, 7'b1000000},  // R13 stop
    {11'b00000000000, 7'b1000000},  // stays stopped
    {11'b00000001000, 7'b0000010},  // R5 fast wake
    {11'b00000000000, 7'b0000010},  // R6 hold
    {11'b00000000011, 7'b0000010},  // R6 result ignored
    {11'b00010000000, 7'b0000010},  // R7 clear fast wake
    {11'b00000000000, 7'b0111010},  // R7 osc, monitor, check
    {11'b00000000000, 7'b0110010},  // checking
    {11'b00000000011, 7'b1110001},  // R8 pass
    {11'b00000100000, 7'b1110000},  // R10 clear
    {11'b00000010000, 7'b1000000},  // R13 stop
    {11'b00000001000, 7'b0101000},  // R11 ordinary wake
    {11'b00000000010, 7'b0101000},  // R11 failed check restarts
    {11'b00000000011, 7'b1110000}   // R11 pass, no flag
  };

  task automatic driveIn(input logic [10:0] v);
    {specialMode, scEnWrStb, scEnWrData, fastWkWrStb, fastWkWrData,
     flagClrStb, stopReq, wakeEvt, clkFail, qcDone, qcPass} = v;
  endtask

  task automatic checkOut(input logic [6:0] exp, input string tag);
    logic [6:0] act;
    act = {selOsc, oscEn, monEn, qcStart, monResetReq, scMode, scFlag};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, let one posedge pass, check at next negedge
  task automatic step(input logic [10:0] v, input logic [6:0] exp, input string tag);
    driveIn(v);
    @(negedge clk);
    checkOut(exp, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    driveIn(11'b0);
    repeat (2) @(negedge clk);
    checkOut(7'b1110000, "R12 reset state");
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    driveIn(11'b0);
    repeat (3) @(negedge clk);
    checkOut(7'b1110000, "R12 reset state");
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17:7], VEC[i][6:0], $sformatf("vector %0d", i));
    end

    // R1 R2: special mode allows repeated writes, never a clear in self-clock
    doReset();
    step(11'b11100000000, 7'b1110000, "R1 special write 1");
    step(11'b11000000000, 7'b1110000, "R1 special write 0");
    step(11'b11100000000, 7'b1110000, "R1 special write 1 again");
    step(11'b10000000100, 7'b0111011, "R1 special writes took effect");
    step(11'b11000000000, 7'b0110011, "R2 clear while self-clock");
    step(11'b10000000011, 7'b1110001, "R2 recovery");
    step(11'b10000100000, 7'b1110000, "R10 clear");
    step(11'b10000000100, 7'b0111011, "R2 enable kept after refused clear");

    // R4: fast wake ignored with enable 0
    doReset();
    step(11'b00011000000, 7'b1110000, "R4 set fast wake only");
    step(11'b00000010000, 7'b1000000, "R13 stop");
    step(11'b00000001000, 7'b0101000, "R4 ordinary wake taken");

    // R10 set beats clear, R13 failure beats stop
    doReset();
    step(11'b01100000000, 7'b1110000, "R1 enable");
    step(11'b00000000100, 7'b0111011, "R3 enter self-clock");
    step(11'b00000100011, 7'b1110001, "R10 set wins over clear");
    step(11'b00000010100, 7'b0111011, "R13 failure over stop");

    // R12: reset from self-clock state
    doReset();
    step(11'b00000000000, 7'b1110000, "R12 after release");

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule